// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine

This block computes a 16-bit link checksum one byte at a time under software control. A host writes each payload byte to a data register. In a single clock cycle the engine folds that byte into the running checksum and adds one to a 12-bit count of absorbed bytes.

A control register restarts both the checksum and the count. The same register reads back the count. Two result registers expose the checksum: one holds the raw internal state and one holds the finished, inverted value that travels on the link.

The checksum is the CCITT 16-bit code processed least significant bit first. That is the reflected polynomial 0x8408, seeded with 0xFFFF, with the result inverted. Host access is a plain 16-bit register bus with a write strobe, a 2-bit word address and combinational read data.

Top module: `byte_crc16_engine`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0000, the raw result register (address 2) reads 0xFFFF and the final result register (address 3) reads 0x0000.
- R2: A write to address 0 with bit 15 set restarts the engine. From the next cycle the raw state is 0xFFFF and the count is 0, whatever was absorbed before.
- R3: A write to the data register (address 1) absorbs bits 7:0 of the write data as one byte and raises the count by one. Bits 15:8 of that write have no effect on the checksum.
- R4: Each absorbed byte updates the state in one cycle, least significant bit first. Per bit, the state shifts right one place and is XORed with 0x8408 when the bit shifted out, XORed with the input bit, is 1.
- R5: Address 2 reads the raw state, and address 3 reads its bitwise inverse.
- R6: After a restart, absorbing 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4, a final result of 0x51DF and a raw state of 0xAE20.
- R7: The count saturates at 0xFFF: further bytes leave it at 0xFFF while the checksum keeps updating.
- R8: Bit 15 of the control register always reads 0, and the count appears in bits 11:0. A control write with bit 15 clear, and writes to addresses 2 and 3, change neither the count nor the checksum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Word address: 0 control, 1 data, 2 raw result, 3 final result |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |

## Verification
The checksum is driven with the fixed four-byte self-test sequence, with junk in the upper byte lanes. This separates the right polynomial, bit order, seed and output inversion from any near variant, and shows that bits 15:8 are ignored. Single bytes 0x00, 0xFF, 0x01 and 0x80 after a restart exercise the all-zero and all-one extremes and both ends of the bit ordering. A run of over four thousand bytes drives the count into saturation while the checksum keeps moving. Control writes with bit 15 clear and writes to the result addresses, placed between data writes, must leave count and checksum untouched.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_RAW   = 2'd2;
  localparam logic [1:0] ADDR_FINAL = 2'd3;
  localparam int         CLEAR_BIT  = 15;

  typedef struct packed {
    logic       clear;
    logic       absorb;
    logic [7:0] byteIn;
  } crcCmd_t;

  // One byte folded into a reflected CRC state, LSB first, unrolled over 8 bits.
  function automatic logic [15:0] crcFoldByte(input logic [15:0] state,
                                              input logic [7:0]  din,
                                              input logic [15:0] poly);
    logic [15:0] s;
    s = state ^ {8'h00, din};
    for (int i = 0; i < 8; i++) begin
      s = s[0] ? ((s >> 1) ^ poly) : (s >> 1);
    end
    return s;
  endfunction

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [15:0]      wrData,
  input  logic [CNT_W-1:0] count,
  input  logic [15:0]      crcState,
  output crcCmd_t          cmd,
  output logic [15:0]      rdData
);

  localparam int PAD_W = 16 - CNT_W;

  logic unusedBits;
  assign unusedBits = ^wrData[14:8];

  always_comb begin
    cmd        = '0;
    cmd.byteIn = wrData[7:0];
    if (wrEn) begin
      unique case (addr)
        ADDR_CTRL: cmd.clear  = wrData[CLEAR_BIT];
        ADDR_DATA: cmd.absorb = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL:  rdData = {{PAD_W{1'b0}}, count};
      ADDR_DATA:  rdData = 16'h0000;
      ADDR_RAW:   rdData = crcState;
      default:    rdData = ~crcState;
    endcase
  end

  // R8: a single write never both restarts and absorbs
  assert_single_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clear, cmd.absorb}));

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int          CNT_W = 12,
  parameter logic [15:0] POLY  = 16'h8408,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcCmd_t          cmd,
  output logic [15:0]      crcState,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [15:0] crcNext;
  assign crcNext = crcFoldByte(crcState, cmd.byteIn, POLY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcState <= SEED;
      count    <= '0;
    end else if (cmd.clear) begin
      crcState <= SEED;
      count    <= '0;
    end else if (cmd.absorb) begin
      crcState <= crcNext;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

  // R2: restart returns seed and zero count
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (crcState == SEED) && (count == '0));

  // R3: each absorbed byte adds one below the limit
  assert_count_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.absorb && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  // R7: count holds at the limit
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.absorb && count == CNT_MAX) |=> count == CNT_MAX);

  // R8: without a command the state is frozen
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.absorb && !cmd.clear) |=> $stable(crcState) && $stable(count));

endmodule

// File: rtl/byte_crc16_engine.sv
module byte_crc16_engine
  import crc16_pkg::*;
#(
  parameter int          CNT_W = 12,
  parameter logic [15:0] POLY  = 16'h8408,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData
);

  crcCmd_t          cmd;
  logic [15:0]      crcState;
  logic [CNT_W-1:0] count;

  crc16_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .count    (count),
    .crcState (crcState),
    .cmd      (cmd),
    .rdData   (rdData)
  );

  crc16_datapath #(.CNT_W(CNT_W), .POLY(POLY), .SEED(SEED)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .crcState (crcState),
    .count    (count)
  );

endmodule

// File: tb/byte_crc16_engine_tb.sv
module byte_crc16_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // data-register write words; upper byte is junk that must be ignored
  localparam logic [15:0] VEC [NVEC] = '{16'h12CC, 16'hA5F5, 16'h00F1, 16'hFFA7,
                                         16'h3300, 16'h00FF, 16'h8001, 16'h7E80};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] modelCrc;
  int modelCnt;
  logic [15:0] v;

  byte_crc16_engine u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] refFold(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] r;
    r = s;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'h0000;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic restart();
    busWrite(2'd0, 16'h8000);
    modelCrc = 16'hFFFF; modelCnt = 0;
  endtask

  task automatic absorb(input logic [15:0] w);
    busWrite(2'd1, w);
    modelCrc = refFold(modelCrc, w[7:0]);
    if (modelCnt < 4095) modelCnt++;
  endtask

  task automatic checkAll(input string req);
    busRead(2'd0, v); check(req, v, 16'(modelCnt));
    busRead(2'd2, v); check(req, v, modelCrc);
    busRead(2'd3, v); check(req, v, ~modelCrc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead(2'd0, v); check("R1 ctrl", v, 16'h0000);
    busRead(2'd2, v); check("R1 raw", v, 16'hFFFF);
    busRead(2'd3, v); check("R1 final", v, 16'h0000);

    // table walk: R3 R4 R5 per byte, self-test on first four (R6)
    restart();
    for (int i = 0; i < NVEC; i++) begin
      absorb(VEC[i]);
      checkAll("R4 R5 table");
      if (i == 3) begin
        busRead(2'd0, v); check("R6 count", v, 16'd4);
        busRead(2'd3, v); check("R6 final", v, 16'h51DF);
        busRead(2'd2, v); check("R6 raw", v, 16'hAE20);
      end
    end

    // R2 restart after absorbed data
    restart();
    checkAll("R2 restart");

    // single-byte patterns after restart, R4
    begin
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
      for (int p = 0; p < 4; p++) begin
        restart();
        absorb({8'h5A, pats[p]});
        checkAll("R4 single byte");
      end
    end

    // R3 upper byte ignored: same low byte, different upper bytes
    restart(); absorb(16'hFF3C);
    busRead(2'd2, v);
    restart(); absorb(16'h003C);
    busRead(2'd2, modelCrc);
    check("R3 upper ignored", v, modelCrc);
    modelCrc = refFold(16'hFFFF, 8'h3C);
    checkAll("R3 one byte");

    // R8 ignored writes
    absorb(16'h0042);
    busWrite(2'd0, 16'h7FFF);
    checkAll("R8 ctrl bit15 clear");
    busWrite(2'd2, 16'h1234);
    busWrite(2'd3, 16'hABCD);
    checkAll("R8 result writes");
    busRead(2'd0, v); check("R8 bit15 reads 0", {15'd0, v[15]}, 16'h0000);

    // R7 saturation
    restart();
    for (int k = 0; k < 4095; k++) absorb(16'(k));
    busRead(2'd0, v); check("R7 reach max", v, 16'h0FFF);
    absorb(16'h00A5);
    absorb(16'h003C);
    checkAll("R7 saturated crc moves");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule